// File: doc/BRIEF.md
# PWM Channel with Period-Boundary Update

This block is one pulse-width-modulation channel. A prescaler divides the input clock by a selectable power of two to produce count ticks, a period counter runs on those ticks, and a comparator sets the output from the counter, the duty value and the period value. Every period opens at the inactive level and switches to the active level after the duty count. A polarity bit chooses whether the active level is high or low.

Software programs the channel through a simple write port with four registers: a mode register, a duty register, a period register and an update register. Mode, duty and period can only be written while the channel is stopped. While it runs, new duty or period values go through the update register. A mode bit picks which of the two the update targets. The value waits and is applied exactly at the next period boundary, so no period is cut short or stretched.

A one-cycle period-start flag marks the first period after enable and every period after it, so software can see when a queued update has landed. A disable request lets the running period finish. Only then does the active status drop, and the output stays at the inactive level.

Top module: `pwm_buffered_chan`

## Requirements
- R1: Writes at offset 0x00 (mode), 0x04 (duty) and 0x08 (period) are accepted only while `active_o` is 0. While the channel is active, such writes have no effect on the output.
- R2: Mode bits 3:0 select the prescaler. Each counter value lasts 2^sel clock cycles, and any selector above 10 behaves as 10.
- R3: With duty D and period P (P>0), the counter runs from 0 to P-1 and wraps. The output is at the inactive level for counts below D and at the active level for counts D to P-1.
- R4: A period value of 0, or D≥P, keeps the output at the inactive level for the whole time the channel is active.
- R5: Mode bit 9 is the polarity. When it is 0 the active level is 1 and the inactive level is 0; when it is 1 the two levels are swapped.
- R6: A write at offset 0x10 (update) is applied only at the end of the running period. Mode bit 10 equal to 0 sends the value to the duty register; equal to 1 sends it to the period register.
- R7: When the update register is written more than once before a boundary, only the last value is applied.
- R8: `period_start_o` is high for one cycle in the first cycle of every period, including the first period after `en_req` is accepted.
- R9: A disable request takes effect at the end of the running period. `active_o` then falls, no new period-start pulse occurs, and the output rests at the inactive level.
- R10: After reset the channel is inactive, `period_start_o` is 0 and `pwm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register byte offset |
| wr_data | input | 16 | Register write data |
| en_req | input | 1 | Start request pulse, ignored while active |
| dis_req | input | 1 | Stop request pulse, applied at end of period |
| pwm_o | output | 1 | Modulated output |
| period_start_o | output | 1 | One-cycle flag in the first cycle of each period |
| active_o | output | 1 | Channel running |

## Verification
All outputs come from registered state. The enable edge shows up as `active_o` and `period_start_o` in the first cycle after that edge, with the counter at 0. An update or a disable registered on a boundary edge is visible in the cycle after that edge, and a count under selector s changes every 2^s cycles. The bench computes, from the requirements alone, an expected output triple for every cycle of a run and queues it just after the enable edge. A monitor samples 3 ns after each rising edge and compares one queued entry per cycle, so each result is checked in exactly the cycle it is due.

// File: rtl/pwm_chan_pkg.sv
`timescale 1ns/1ps
package pwm_chan_pkg;

    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 5;
    localparam int SEL_W   = 4;
    localparam int SEL_MAX = 10;
    localparam int PRE_W   = SEL_MAX;

    localparam logic [ADDR_W-1:0] OFS_MODE   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DUTY   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_UPD    = 5'h10;

    localparam int BIT_POL = 9;
    localparam int BIT_TGT = 10;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             pol;
        logic             tgt;
    } mode_t;

endpackage

// File: rtl/pwm_chan_cfg.sv
`timescale 1ns/1ps
module pwm_chan_cfg
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W_P = CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W_P-1:0]  wr_data,
    input  logic                chan_active,
    input  logic                period_edge,
    output mode_t               mode,
    output logic [SEL_W-1:0]    sel_eff,
    output logic [CNT_W_P-1:0]  duty,
    output logic [CNT_W_P-1:0]  period
);

    typedef struct packed {
        mode_t              mode;
        logic [CNT_W_P-1:0] duty;
        logic [CNT_W_P-1:0] period;
        logic [CNT_W_P-1:0] upd_val;
        logic               upd_pend;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic upd_wr;
    logic [CNT_W_P-1:0] upd_eff;

    always_comb begin
        cfg_d   = cfg_q;
        upd_wr  = wr_en && (wr_addr == OFS_UPD);
        upd_eff = upd_wr ? wr_data : cfg_q.upd_val;

        if (wr_en && !chan_active) begin
            case (wr_addr)
                OFS_MODE: begin
                    cfg_d.mode.sel = wr_data[SEL_W-1:0];
                    cfg_d.mode.pol = wr_data[BIT_POL];
                    cfg_d.mode.tgt = wr_data[BIT_TGT];
                end
                OFS_DUTY:   cfg_d.duty   = wr_data;
                OFS_PERIOD: cfg_d.period = wr_data;
                default: ;
            endcase
        end

        if (period_edge && (upd_wr || cfg_q.upd_pend)) begin
            if (cfg_q.mode.tgt) cfg_d.period = upd_eff;
            else                cfg_d.duty   = upd_eff;
            cfg_d.upd_pend = 1'b0;
        end else if (upd_wr) begin
            cfg_d.upd_pend = 1'b1;
            cfg_d.upd_val  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode    = cfg_q.mode;
    assign duty    = cfg_q.duty;
    assign period  = cfg_q.period;
    assign sel_eff = (cfg_q.mode.sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : cfg_q.mode.sel;

endmodule

// File: rtl/pwm_chan_presc.sv
`timescale 1ns/1ps
module pwm_chan_presc
    import pwm_chan_pkg::*;
#(
    parameter int PRE_W_P = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRE_W_P-1:0] pre_d, pre_q;
    logic [PRE_W_P-1:0] mask;

    always_comb begin
        mask  = ~({PRE_W_P{1'b1}} << sel);
        tick  = run && (pre_q == mask);
        if (!run || tick) pre_d = '0;
        else              pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/pwm_chan_timebase.sv
`timescale 1ns/1ps
module pwm_chan_timebase #(
    parameter int CNT_W_P = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               en_req,
    input  logic               dis_req,
    input  logic [CNT_W_P-1:0] duty,
    input  logic [CNT_W_P-1:0] period,
    input  logic               pol,
    output logic               active,
    output logic               start,
    output logic               period_edge,
    output logic               pwm,
    output logic [CNT_W_P-1:0] cnt
);

    typedef struct packed {
        logic               active;
        logic               stop_pend;
        logic               start;
        logic [CNT_W_P-1:0] cnt;
    } tb_t;

    tb_t tb_d, tb_q;
    logic wrap;
    logic level;

    always_comb begin
        wrap        = (period == '0) || (tb_q.cnt == period - CNT_W_P'(1));
        period_edge = tb_q.active && tick && wrap;

        tb_d       = tb_q;
        tb_d.start = 1'b0;
        if (!tb_q.active) begin
            if (en_req) begin
                tb_d.active    = 1'b1;
                tb_d.cnt       = '0;
                tb_d.start     = 1'b1;
                tb_d.stop_pend = 1'b0;
            end
        end else begin
            if (dis_req) tb_d.stop_pend = 1'b1;
            if (tick) begin
                if (wrap) begin
                    tb_d.cnt = '0;
                    if (tb_q.stop_pend || dis_req) begin
                        tb_d.active    = 1'b0;
                        tb_d.stop_pend = 1'b0;
                    end else begin
                        tb_d.start = 1'b1;
                    end
                end else begin
                    tb_d.cnt = tb_q.cnt + 1'b1;
                end
            end
        end

        level = tb_q.active && (period != '0) && (tb_q.cnt >= duty) && (tb_q.cnt < period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign active = tb_q.active;
    assign start  = tb_q.start;
    assign cnt    = tb_q.cnt;
    assign pwm    = level ^ pol;

endmodule

// File: rtl/pwm_buffered_chan.sv
`timescale 1ns/1ps
module pwm_buffered_chan
    import pwm_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              en_req,
    input  logic              dis_req,
    output logic              pwm_o,
    output logic              period_start_o,
    output logic              active_o
);

    mode_t             mode_w;
    logic [SEL_W-1:0]  sel_w;
    logic [CNT_W-1:0]  duty_w;
    logic [CNT_W-1:0]  period_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              tick_w;
    logic              period_edge;
    logic              pol_w;

    assign pol_w = mode_w.pol;

    pwm_chan_cfg #(.CNT_W_P(CNT_W)) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .chan_active (active_o),
        .period_edge (period_edge),
        .mode        (mode_w),
        .sel_eff     (sel_w),
        .duty        (duty_w),
        .period      (period_w)
    );

    pwm_chan_presc #(.PRE_W_P(PRE_W)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active_o),
        .sel   (sel_w),
        .tick  (tick_w)
    );

    pwm_chan_timebase #(.CNT_W_P(CNT_W)) i_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_w),
        .en_req      (en_req),
        .dis_req     (dis_req),
        .duty        (duty_w),
        .period      (period_w),
        .pol         (pol_w),
        .active      (active_o),
        .start       (period_start_o),
        .period_edge (period_edge),
        .pwm         (pwm_o),
        .cnt         (cnt_w)
    );

endmodule

// File: rtl/pwm_buffered_chan_chk.sv
`timescale 1ns/1ps
module pwm_buffered_chan_chk #(
    parameter int CNT_W_P = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               active,
    input logic               start,
    input logic               pwm,
    input logic               pol,
    input logic               edge_w,
    input logic [CNT_W_P-1:0] cnt,
    input logic [CNT_W_P-1:0] duty,
    input logic [CNT_W_P-1:0] period
);

    // R10
    always_comb begin
        if (!rst_n) begin
            reset_idle_chk: assert (!active && !start);
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && period != '0) |-> (cnt < period));

    // R3
    lead_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt < duty) |-> (pwm == pol));

    // R4
    no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0 || duty >= period) |-> (pwm == pol));

    // R6
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$past(edge_w)) |-> ($stable(duty) && $stable(period)));

    // R8
    first_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> start);

    // R8
    start_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> active);

    // R9
    stop_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(edge_w));

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (pwm == pol && !start));

endmodule

bind pwm_buffered_chan pwm_buffered_chan_chk #(.CNT_W_P(pwm_chan_pkg::CNT_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active_o),
    .start  (period_start_o),
    .pwm    (pwm_o),
    .pol    (pol_w),
    .edge_w (period_edge),
    .cnt    (cnt_w),
    .duty   (duty_w),
    .period (period_w)
);

// File: tb/test_pwm_buffered_chan.sv
`timescale 1ns/1ps
module test_pwm_buffered_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        en_req = 1'b0;
    logic        dis_req = 1'b0;
    logic        pwm_o, period_start_o, active_o;

    always #5 clk = ~clk;

    typedef struct {
        bit    pwm;
        bit    st;
        bit    act;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    pwm_buffered_chan i_pwm_buffered_chan (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .en_req         (en_req),
        .dis_req        (dis_req),
        .pwm_o          (pwm_o),
        .period_start_o (period_start_o),
        .active_o       (active_o)
    );

    // monitor: one expected entry per cycle, sampled 3 ns after the edge
    initial begin : monitor
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (pwm_o !== e.pwm || period_start_o !== e.st || active_o !== e.act) begin
                    errors++;
                    $display("FAIL %s actual pwm=%0b start=%0b active=%0b expected pwm=%0b start=%0b active=%0b",
                             e.tag, pwm_o, period_start_o, active_o, e.pwm, e.st, e.act);
                end
            end
        end
    end

    task automatic reg_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] mode_word(int sel, bit pol, bit tgt);
        return {5'b0, tgt, pol, 5'b0, sel[3:0]};
    endfunction

    // configure, enable, queue the expected per-cycle triple, then drive events
    task automatic run_seg(string tag, int sel, bit pol, bit tgt, int d0, int p0,
                           int len, int dis_at, int ua, int uv, int ub, int ubv, int iw);
        int se, dd, pp, pos, ll;
        bit pend, stp, act;
        int pv;
        exp_t e;
        reg_wr(5'h00, mode_word(sel, pol, tgt));
        reg_wr(5'h04, 16'(d0));
        reg_wr(5'h08, 16'(p0));
        @(negedge clk);
        en_req = 1'b1;
        @(posedge clk);
        #1;
        se = (sel > 10) ? 10 : sel;
        dd = d0; pp = p0; pos = 0; pend = 0; pv = 0; stp = 0; act = 1;
        for (int j = 0; j < len; j++) begin
            e.tag = tag;
            if (act) begin
                ll    = ((pp == 0) ? 1 : pp) << se;
                e.act = 1;
                e.st  = (pos == 0);
                e.pwm = ((pp != 0) && ((pos >> se) >= dd) && ((pos >> se) < pp)) ^ pol;
            end else begin
                ll    = 1;
                e.act = 0;
                e.st  = 0;
                e.pwm = pol;
            end
            exp_q.push_back(e);
            if (j == ua) begin pend = 1; pv = uv; end
            if (j == ub) begin pend = 1; pv = ubv; end
            if (j == dis_at) stp = 1;
            if (act) begin
                if (pos == ll - 1) begin
                    if (pend) begin
                        if (tgt) pp = pv; else dd = pv;
                        pend = 0;
                    end
                    pos = 0;
                    if (stp) act = 0;
                end else begin
                    pos++;
                end
            end
        end
        @(negedge clk);
        en_req = 1'b0;
        for (int j = 0; j < len; j++) begin
            dis_req = (j == dis_at);
            wr_en   = 1'b0;
            if (j == ua) begin
                wr_en = 1'b1; wr_addr = 5'h10; wr_data = 16'(uv);
            end else if (j == ub) begin
                wr_en = 1'b1; wr_addr = 5'h10; wr_data = 16'(ubv);
            end else if (iw >= 0 && j == iw) begin
                wr_en = 1'b1; wr_addr = 5'h04; wr_data = 16'd0;
            end else if (iw >= 0 && j == iw + 1) begin
                wr_en = 1'b1; wr_addr = 5'h08; wr_data = 16'd2;
            end else if (iw >= 0 && j == iw + 2) begin
                wr_en = 1'b1; wr_addr = 5'h00; wr_data = mode_word(0, !pol, tgt);
            end
            @(negedge clk);
        end
        dis_req = 1'b0;
        wr_en   = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before all checks finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (pwm_o !== 1'b0 || period_start_o !== 1'b0 || active_o !== 1'b0) begin
            errors++;
            $display("FAIL R10 actual pwm=%0b start=%0b active=%0b expected 0 0 0",
                     pwm_o, period_start_o, active_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R8 R9: D=3 P=8, disable mid second period
        run_seg("R3_R8_R9 basic", 0, 0, 0, 3, 8, 30, 12, -1, 0, -1, 0, -1);
        // R2: selector 2 stretches each count to 4 cycles
        run_seg("R2 prescale", 2, 0, 0, 1, 4, 40, 5, -1, 0, -1, 0, -1);
        // R2: selector 15 behaves as 10
        run_seg("R2 clamp", 15, 0, 0, 1, 2, 2060, 0, -1, 0, -1, 0, -1);
        // R5: inverted polarity, selector 1
        run_seg("R5 polarity", 1, 1, 0, 2, 5, 30, 3, -1, 0, -1, 0, -1);
        // R4: period 0 keeps the output inactive
        run_seg("R4 zero period", 0, 0, 0, 0, 0, 10, 4, -1, 0, -1, 0, -1);
        // R4: duty equal to period, inverted polarity
        run_seg("R4 full duty", 0, 1, 0, 6, 6, 12, 2, -1, 0, -1, 0, -1);
        // R6: update to duty lands at the first boundary
        run_seg("R6 duty update", 0, 0, 0, 2, 6, 30, 14, 2, 5, -1, 0, -1);
        // R6: update to period lands at the second boundary
        run_seg("R6 period update", 0, 0, 1, 2, 6, 30, 20, 8, 3, -1, 0, -1);
        // R7: two updates in one period, last value wins
        run_seg("R7 last update wins", 0, 0, 0, 6, 8, 40, 20, 1, 1, 3, 4, -1);
        // R1: direct writes while active are ignored
        run_seg("R1 ignored writes", 0, 0, 0, 2, 6, 30, 10, -1, 0, -1, 0, 3);

        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule